// File: doc/BRIEF.md
# LSB-First Serial Register Port

This block is a four-wire serial slave that lets an external controller read and write a small register file. An active-low chip select frames each transaction. Within a frame the controller clocks in a direction bit, a 7-bit address and 8 data bits, for 16 serial clock cycles in all. Address and data travel least significant bit first. On a read, the block returns the addressed register on the serial output, also LSB first. It raises an output enable only while those data bits are being shifted out, so the serial input and output can share one wire.

The block works entirely in the system clock domain. Chip select, serial clock and serial input pass through two-flop synchronizers. Edges of the serial clock are found by comparing successive synchronized samples. Input bits are taken on rising serial clock edges, and output bits are launched on falling edges. Because of this oversampling, the system clock must run at least eight times faster than SCK. A 160 MHz system clock therefore covers a 20 MHz serial clock.

The register file holds NCFG writable configuration registers, which load parameter defaults on reset, and NSTAT read-only status registers taken from a parallel input. The configuration registers are visible in parallel at `cfg_o`.

Top module: `lsb_serial_regport`

## Requirements
- R1: While `rst_n` is low, every configuration register takes its default from CFG_INIT (register k in bits k*8+7..k*8), `sdo_oe` is 0 and the frame state returns to idle.
- R2: A frame's first SDI bit, sampled on a rising SCK edge, selects the direction (1 = read, 0 = write). The next 7 bits are the address, LSB first, and the 8 bits after that are the data, LSB first.
- R3: A write to address k < NCFG replaces configuration register k with the 8 data bits at the 16th rising SCK edge of the frame, and `cfg_o[k*8 +: 8]` then shows the new value.
- R4: If chip select is released before the 16th rising SCK edge, the frame is discarded and no register changes.
- R5: On a read, data bit 0 appears on `sdo` at the falling SCK edge after the 8th rising edge. Each later falling edge presents the next higher bit, up to bit 7.
- R6: `sdo_oe` is 1 only in a read frame, from the falling edge after the 8th rising edge until the falling edge after the 16th rising edge or the release of chip select, whichever comes first. It is never 1 in a write frame.
- R7: Addresses NCFG to NCFG+NSTAT-1 read `stat_i[(a-NCFG)*8 +: 8]`, and writes to them change nothing.
- R8: Addresses at or above NCFG+NSTAT read as 0, and writes to them change nothing.
- R9: SCK edges after the 16th in a frame are ignored, and a new frame begins only after chip select has been released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCK rate |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select framing a transaction |
| sck | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the serial output |
| stat_i | input | NSTAT*8 | Status register values, read-only |
| cfg_o | output | NCFG*8 | Configuration register contents |

## Verification
Every one of the 128 addresses is read, so the three decode regions (configuration, status and unmapped) are each checked against the value the bench computes. A bit-reversed address would land in the wrong region and fail. Each configuration register is written with all-zeros, all-ones, walking-one and address-dependent patterns, then read back. This separates an LSB-first from an MSB-first data path and shows whether a write reaches only its own register. Truncated frames of 1, 8 and 15 bits, a read cut off mid-data, and over-long 20-bit frames whose trailing bits differ from the data show whether commitment waits for exactly the 16th edge while chip select is held. A sweep of writes across every non-configuration address shows that none of them disturbs the registers.

// File: rtl/lsb_serial_regport.sv
module lsb_serial_regport #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int NCFG = 4,
  parameter int NSTAT = 2,
  parameter logic [NCFG*DW-1:0] CFG_INIT = 32'h5A00FF81
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                sdi,
  output logic                sdo,
  output logic                sdo_oe,
  input  logic [NSTAT*DW-1:0] stat_i,
  output logic [NCFG*DW-1:0]  cfg_o
);
  localparam int FRAME = 1 + AW + DW;
  localparam int CW = $clog2(FRAME + 1);

  logic [2:0]    sck_p;
  logic [1:0]    cs_p, sdi_p;
  logic [CW-1:0] cnt;
  logic          rw_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] sh_q, rd, wdat;
  logic [DW-1:0] cfg_q [NCFG];

  wire cs_act   = ~cs_p[1];
  wire sdi_s    = sdi_p[1];
  wire sck_rise = sck_p[1] & ~sck_p[2];
  wire sck_fall = ~sck_p[1] & sck_p[2];
  wire wr       = cs_act & sck_rise & ~rw_q & (cnt == CW'(FRAME - 1));
  assign wdat   = {sdi_s, sh_q[DW-1:1]};

  for (genvar g = 0; g < NCFG; g++) begin : g_out
    assign cfg_o[g*DW +: DW] = cfg_q[g];
  end

  always_comb begin
    rd = '0;
    for (int k = 0; k < NCFG; k++)
      if (addr_q == AW'(k)) rd = cfg_q[k];
    for (int k = 0; k < NSTAT; k++)
      if (addr_q == AW'(NCFG + k)) rd = stat_i[k*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= '1;
      sdi_p <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck};
      cs_p  <= {cs_p[0], cs_n};
      sdi_p <= {sdi_p[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rw_q   <= 1'b0;
      addr_q <= '0;
      sh_q   <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (!cs_act) begin
      cnt    <= '0;
      rw_q   <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      if (sck_rise && cnt != CW'(FRAME)) begin
        cnt <= cnt + 1'b1;
        if (cnt == '0) rw_q <= sdi_s;
        else if (cnt <= CW'(AW)) addr_q <= {sdi_s, addr_q[AW-1:1]};
        else if (!rw_q) sh_q <= wdat;
      end
      if (sck_fall && rw_q) begin
        if (cnt == CW'(1 + AW)) begin
          sdo    <= rd[0];
          sh_q   <= rd >> 1;
          sdo_oe <= 1'b1;
        end else if (cnt > CW'(1 + AW) && cnt < CW'(FRAME)) begin
          sdo  <= sh_q[0];
          sh_q <= sh_q >> 1;
        end else if (cnt == CW'(FRAME)) begin
          sdo_oe <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCFG; k++) cfg_q[k] <= CFG_INIT[k*DW +: DW];
    end else if (wr) begin
      for (int k = 0; k < NCFG; k++)
        if (addr_q == AW'(k)) cfg_q[k] <= wdat;
    end
  end

  a_r3_cfg_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg_o));
  a_r5_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(sdo));
  a_r6_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> rw_q);
  a_r4_idle_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (cnt == '0 && !sdo_oe));
  a_r9_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAME));
endmodule

// File: tb/lsb_serial_regport_tb.sv
module lsb_serial_regport_tb;
  localparam int H = 5;
  localparam logic [31:0] INIT = 32'h5A00FF81;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, sdi = 0;
  logic sdo, sdo_oe;
  logic [15:0] stat_i = 16'h3CC3;
  logic [31:0] cfg_o;
  logic [7:0] exp_cfg [4];
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  lsb_serial_regport u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .stat_i(stat_i), .cfg_o(cfg_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_flat();
    return {exp_cfg[3], exp_cfg[2], exp_cfg[1], exp_cfg[0]};
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    if (a < 4) return exp_cfg[a];
    if (a < 6) return stat_i[(a-4)*8 +: 8];
    return 8'h00;
  endfunction

  task automatic frame(input bit rdb, input logic [6:0] a, input logic [7:0] d,
                       input int nbits, output logic [7:0] rq, output int oe_bad);
    logic bitv;
    rq = '0;
    oe_bad = 0;
    @(negedge clk) cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i == 0) bitv = rdb;
      else if (i < 8) bitv = a[i-1];
      else if (i < 16) bitv = d[i-8];
      else bitv = ~d[i-16];
      sdi = bitv;
      repeat (H) @(negedge clk);
      if (rdb && i >= 8 && i < 16) begin
        rq[i-8] = sdo;
        if (!sdo_oe) oe_bad++;
      end else if (sdo_oe) oe_bad++;
      sck = 1;
      repeat (H) @(negedge clk);
      sck = 0;
    end
    repeat (H) @(negedge clk);
    if (sdo_oe != (rdb && nbits >= 8 && nbits < 16)) oe_bad++;
    cs_n = 1;
    repeat (4) @(negedge clk);
    if (sdo_oe) oe_bad++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rq;
    int ob;
    logic [7:0] pats [10];
    for (int k = 0; k < 4; k++) exp_cfg[k] = INIT[k*8 +: 8];
    repeat (3) @(negedge clk);
    check("R1 reset cfg_o", int'(cfg_o), int'(INIT));
    check("R1 reset sdo_oe", int'(sdo_oe), 0);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 R5 R7 R8: read every address
    for (int a = 0; a < 128; a++) begin
      frame(1'b1, 7'(a), 8'h00, 16, rq, ob);
      check($sformatf("R5 R2 read addr %0d", a), int'(rq), int'(exp_read(a)));
      check("R6 oe window on read", ob, 0);
    end

    // R3: write patterns to each configuration register
    pats[0] = 8'h00; pats[1] = 8'hFF;
    for (int j = 0; j < 8; j++) pats[j+2] = 8'(1 << j);
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 10; p++) begin
        logic [7:0] v;
        v = (p == 9) ? 8'(k * 37 + 5) : pats[p];
        frame(1'b0, 7'(k), v, 16, rq, ob);
        exp_cfg[k] = v;
        check("R3 cfg_o after write", int'(cfg_o), int'(exp_flat()));
        check("R6 oe low in write", ob, 0);
        frame(1'b1, 7'(k), 8'h00, 16, rq, ob);
        check("R3 R5 read back", int'(rq), int'(v));
      end
    end

    // R7 R8: writes outside configuration space change nothing
    for (int a = 4; a < 128; a++) frame(1'b0, 7'(a), 8'hE7, 16, rq, ob);
    check("R7 R8 cfg_o unchanged", int'(cfg_o), int'(exp_flat()));
    frame(1'b1, 7'd4, 8'h00, 16, rq, ob);
    check("R7 status 4 after write", int'(rq), 32'hC3);
    frame(1'b1, 7'd5, 8'h00, 16, rq, ob);
    check("R7 status 5 after write", int'(rq), 32'h3C);
    stat_i = 16'h96A1;
    frame(1'b1, 7'd5, 8'h00, 16, rq, ob);
    check("R7 status follows input", int'(rq), 32'h96);
    frame(1'b1, 7'd100, 8'h00, 16, rq, ob);
    check("R8 unmapped reads zero", int'(rq), 0);

    // R4: truncated writes are discarded
    frame(1'b0, 7'd2, 8'h77, 15, rq, ob);
    check("R4 abort at 15 bits", int'(cfg_o), int'(exp_flat()));
    frame(1'b0, 7'd1, 8'h77, 8, rq, ob);
    check("R4 abort at 8 bits", int'(cfg_o), int'(exp_flat()));
    frame(1'b0, 7'd0, 8'h77, 1, rq, ob);
    check("R4 abort at 1 bit", int'(cfg_o), int'(exp_flat()));

    // R6: read cut off mid-data releases the output
    frame(1'b1, 7'd3, 8'h00, 11, rq, ob);
    check("R6 oe on truncated read", ob, 0);
    check("R6 oe after release", int'(sdo_oe), 0);
    frame(1'b1, 7'd3, 8'h00, 16, rq, ob);
    check("R5 read after truncated read", int'(rq), int'(exp_cfg[3]));

    // R9: extra SCK edges ignored
    frame(1'b0, 7'd2, 8'hC6, 20, rq, ob);
    exp_cfg[2] = 8'hC6;
    check("R9 long write commits once", int'(cfg_o), int'(exp_flat()));
    frame(1'b1, 7'd2, 8'h00, 20, rq, ob);
    check("R9 long read value", int'(rq), 32'hC6);
    check("R9 R6 oe on long read", ob, 0);

    // R1: reset mid-run restores defaults
    frame(1'b0, 7'd0, 8'h11, 16, rq, ob);
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 reset restores defaults", int'(cfg_o), int'(INIT));
    @(negedge clk) rst_n = 1;
    for (int k = 0; k < 4; k++) exp_cfg[k] = INIT[k*8 +: 8];
    repeat (3) @(negedge clk);
    frame(1'b1, 7'd0, 8'h00, 16, rq, ob);
    check("R1 R5 read default after reset", int'(rq), int'(INIT[7:0]));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule